// File: doc/BRIEF.md
# Conditional Branch and Restart Decision Unit

This unit sits beside an 8-bit processor's instruction sequencer and decides what happens to the program counter when the sequencer presents a control-transfer opcode. For each opcode strobed in with a valid pulse, it classifies the opcode as a jump, call, return, restart or jump-through-HL. For the conditional forms it evaluates one of eight flag tests against the current flag byte. It reports whether the transfer is taken and whether a return address must be pushed or popped. It also gives the restart target address and the number of clock states the instruction occupies, which depends on whether the branch was taken.

The unit does not move any data. Fetching the address operand, the stack memory cycles and the program-counter arithmetic are left to the sequencer, which acts on the registered decision one clock after it presents the opcode.

Top module: `branch_decide`

## Requirements
- R1: Opcode bits 5:3 pick the condition. Code 0 = zero flag clear, 1 = zero flag set, 2 = carry clear, 3 = carry set, 4 = parity flag clear (odd), 5 = parity flag set (even), 6 = sign clear (plus), 7 = sign set (minus). In the flag byte, sign is bit 7, zero is bit 6, parity is bit 2 and carry is bit 0; the other flag bits have no effect.
- R2: An opcode of the form 11ccc010 is a conditional jump. It is taken when its condition holds and then reports 10 states, otherwise 7. It never requests a push or a pop.
- R3: An opcode of the form 11ccc100 is a conditional call. It is taken when its condition holds and then requests a push and reports 18 states. When not taken it reports 9 states and no push.
- R4: An opcode of the form 11ccc000 is a conditional return. It is taken when its condition holds and then requests a pop and reports 12 states. When not taken it reports 6 states and no pop.
- R5: The unconditional forms are always taken, whatever the flags. 0xC3 (jump) reports 10 states. 0xCD (call) requests a push and reports 18. 0xC9 (return) requests a pop and reports 10. 0xE9 (jump to HL) reports 6 with no stack request.
- R6: An opcode of the form 11nnn111 is a restart. It is always taken, requests a push, reports 12 states and gives a vector address equal to nnn*8 (0x00 to 0x38). For every other opcode the vector address is 0.
- R7: Any opcode outside the groups above gives taken low, no push, no pop, a state count of 0 and a vector of 0.
- R8: All outputs are registered. A valid strobe in cycle N gives the result with outValid high after the following clock edge. A cycle without the strobe gives outValid, taken, pushReq and popReq low, and stateCount and vectorAddr 0, after that edge.
- R9: While reset is asserted, all outputs are 0.
- R10: pushReq and popReq are never high together, and neither is high without taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Opcode and flags are valid this cycle |
| opcode | input | 8 | Instruction opcode |
| flags | input | 8 | Current flag byte (S bit 7, Z bit 6, P bit 2, CY bit 0) |
| outValid | output | 1 | Decision registered from the previous cycle's strobe |
| taken | output | 1 | Control transfer happens |
| pushReq | output | 1 | Return address must be pushed |
| popReq | output | 1 | Return address must be popped |
| vectorAddr | output | ADDR_W | Restart target address |
| stateCount | output | CNT_W | Clock states taken by the instruction |

## Verification
A wrong opcode classification in the decoder shows one cycle later as a state count from the wrong group, such as 7/10 where 9/18 is expected. It can also show as a stack request that should not appear. A wrong condition selection shows only for flag bytes on which the intended test and the substituted test disagree. The random stimulus therefore sweeps all eight condition codes against varied flag bytes, and every decision is compared on the cycle after its strobe. A stale output register shows on the first idle cycle after a strobe, as a taken or request bit that does not clear.

// File: rtl/branch_decide_pkg.sv
package branch_decide_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_CJMP, K_CCALL, K_CRET, K_JMP, K_CALL, K_RET, K_HLJMP, K_RST
  } xferKind_t;

  // strobes from control decode to datapath
  typedef struct packed {
    xferKind_t  kind;
    logic [2:0] sel;   // condition code or restart index
  } ctrlStrb_t;

  // flag byte bit positions (fixed by the flag register layout)
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_P  = 2;
  localparam int FLAG_CY = 0;

  localparam int ST_CJMP_NT  = 7;
  localparam int ST_CJMP_T   = 10;
  localparam int ST_CCALL_NT = 9;
  localparam int ST_CALL     = 18;
  localparam int ST_CRET_NT  = 6;
  localparam int ST_CRET_T   = 12;
  localparam int ST_JMP      = 10;
  localparam int ST_RET      = 10;
  localparam int ST_HLJMP    = 6;
  localparam int ST_RST      = 12;

endpackage

// File: rtl/branch_decide_ctrl.sv
module branch_decide_ctrl
  import branch_decide_pkg::*;
(
  input  logic [7:0] opcode,
  output ctrlStrb_t  strb
);

  always_comb begin
    strb.sel  = opcode[5:3];
    strb.kind = K_NONE;
    if (opcode[7:6] == 2'b11) begin
      unique case (opcode[2:0])
        3'b010: strb.kind = K_CJMP;
        3'b100: strb.kind = K_CCALL;
        3'b000: strb.kind = K_CRET;
        3'b111: strb.kind = K_RST;
        default: begin
          case (opcode)
            8'hC3:   strb.kind = K_JMP;
            8'hCD:   strb.kind = K_CALL;
            8'hC9:   strb.kind = K_RET;
            8'hE9:   strb.kind = K_HLJMP;
            default: strb.kind = K_NONE;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/branch_decide_dp.sv
module branch_decide_dp
  import branch_decide_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  ctrlStrb_t         strb,
  input  logic [7:0]        flags,
  output logic              outValid,
  output logic              taken,
  output logic              pushReq,
  output logic              popReq,
  output logic [ADDR_W-1:0] vectorAddr,
  output logic [CNT_W-1:0]  stateCount
);

  localparam int NCOND = 8;
  localparam int NPAIR = NCOND / 2;
  localparam int VEC_SHIFT = 3;

  // flag tested by each condition pair, in condition-code order
  localparam int PAIR_BIT [NPAIR] = '{FLAG_Z, FLAG_CY, FLAG_P, FLAG_S};

  logic [NCOND-1:0] condVec;
  logic             condMet;
  logic             unusedFlags;

  assign unusedFlags = ^{flags[5:3], flags[1]};

  genvar gi;
  generate
    for (gi = 0; gi < NPAIR; gi++) begin : g_pair
      assign condVec[2*gi]   = ~flags[PAIR_BIT[gi]];
      assign condVec[2*gi+1] =  flags[PAIR_BIT[gi]];
    end
  endgenerate

  assign condMet = condVec[strb.sel];

  logic              nxtTaken, nxtPush, nxtPop;
  logic [ADDR_W-1:0] nxtVec;
  logic [CNT_W-1:0]  nxtCnt;

  always_comb begin
    nxtTaken = 1'b0;
    nxtPush  = 1'b0;
    nxtPop   = 1'b0;
    nxtVec   = '0;
    nxtCnt   = '0;
    unique case (strb.kind)
      K_CJMP: begin
        nxtTaken = condMet;
        nxtCnt   = condMet ? CNT_W'(ST_CJMP_T) : CNT_W'(ST_CJMP_NT);
      end
      K_CCALL: begin
        nxtTaken = condMet;
        nxtPush  = condMet;
        nxtCnt   = condMet ? CNT_W'(ST_CALL) : CNT_W'(ST_CCALL_NT);
      end
      K_CRET: begin
        nxtTaken = condMet;
        nxtPop   = condMet;
        nxtCnt   = condMet ? CNT_W'(ST_CRET_T) : CNT_W'(ST_CRET_NT);
      end
      K_JMP: begin
        nxtTaken = 1'b1;
        nxtCnt   = CNT_W'(ST_JMP);
      end
      K_CALL: begin
        nxtTaken = 1'b1;
        nxtPush  = 1'b1;
        nxtCnt   = CNT_W'(ST_CALL);
      end
      K_RET: begin
        nxtTaken = 1'b1;
        nxtPop   = 1'b1;
        nxtCnt   = CNT_W'(ST_RET);
      end
      K_HLJMP: begin
        nxtTaken = 1'b1;
        nxtCnt   = CNT_W'(ST_HLJMP);
      end
      K_RST: begin
        nxtTaken = 1'b1;
        nxtPush  = 1'b1;
        nxtVec   = ADDR_W'(strb.sel) << VEC_SHIFT;
        nxtCnt   = CNT_W'(ST_RST);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !opValid) begin
      outValid   <= 1'b0;
      taken      <= 1'b0;
      pushReq    <= 1'b0;
      popReq     <= 1'b0;
      vectorAddr <= '0;
      stateCount <= '0;
    end else begin
      outValid   <= 1'b1;
      taken      <= nxtTaken;
      pushReq    <= nxtPush;
      popReq     <= nxtPop;
      vectorAddr <= nxtVec;
      stateCount <= nxtCnt;
    end
  end

endmodule

// File: rtl/branch_decide.sv
module branch_decide
  import branch_decide_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        flags,
  output logic              outValid,
  output logic              taken,
  output logic              pushReq,
  output logic              popReq,
  output logic [ADDR_W-1:0] vectorAddr,
  output logic [CNT_W-1:0]  stateCount
);

  ctrlStrb_t strb;

  branch_decide_ctrl u_ctrl (
    .opcode (opcode),
    .strb   (strb)
  );

  branch_decide_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .strb       (strb),
    .flags      (flags),
    .outValid   (outValid),
    .taken      (taken),
    .pushReq    (pushReq),
    .popReq     (popReq),
    .vectorAddr (vectorAddr),
    .stateCount (stateCount)
  );

endmodule

// File: rtl/branch_decide_chk.sv
module branch_decide_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [7:0]        opcode,
  input logic              outValid,
  input logic              taken,
  input logic              pushReq,
  input logic              popReq,
  input logic [ADDR_W-1:0] vectorAddr,
  input logic [CNT_W-1:0]  stateCount
);

  logic isRst, isCjmp, unusedSig;
  assign isRst  = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b111);
  assign isCjmp = (opcode[7:6] == 2'b11) && (opcode[2:0] == 3'b010);
  assign unusedSig = ^opcode[5:3];

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pushReq && popReq));  // R10
  AST_REQ_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq || popReq) |-> taken);  // R10
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> outValid);  // R8
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!outValid && !taken && !pushReq && !popReq && stateCount == '0));  // R8
  AST_RST_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isRst) |=> (taken && pushReq && !popReq && stateCount == CNT_W'(12)));  // R6
  AST_CJMP_NO_STACK: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isCjmp) |=> (!pushReq && !popReq && vectorAddr == '0));  // R2

endmodule

bind branch_decide branch_decide_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opcode     (opcode),
  .outValid   (outValid),
  .taken      (taken),
  .pushReq    (pushReq),
  .popReq     (popReq),
  .vectorAddr (vectorAddr),
  .stateCount (stateCount)
);

// File: tb/sim_branch_decide.sv
`timescale 1ns/1ps
module sim_branch_decide;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [7:0]        opcode = '0;
  logic [7:0]        flags = '0;
  logic              outValid, taken, pushReq, popReq;
  logic [ADDR_W-1:0] vectorAddr;
  logic [CNT_W-1:0]  stateCount;

  int checks = 0;
  int errors = 0;
  int seed   = 32'h5EED_0042;

  always #10 clk = ~clk;

  branch_decide #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode), .flags(flags),
    .outValid(outValid), .taken(taken), .pushReq(pushReq), .popReq(popReq),
    .vectorAddr(vectorAddr), .stateCount(stateCount)
  );

  // expected: {taken, push, pop, vector[15:0], count[4:0]}
  function automatic logic [23:0] refModel(input logic [7:0] op, input logic [7:0] f);
    logic t, pu, po, met, fb;
    logic [15:0] v;
    logic [4:0] c;
    case (op[5:4])
      2'd0: fb = f[6];
      2'd1: fb = f[0];
      2'd2: fb = f[2];
      default: fb = f[7];
    endcase
    met = op[3] ? fb : ~fb;
    t = 0; pu = 0; po = 0; v = 0; c = 0;
    if (op == 8'hC3) begin t = 1; c = 10; end
    else if (op == 8'hCD) begin t = 1; pu = 1; c = 18; end
    else if (op == 8'hC9) begin t = 1; po = 1; c = 10; end
    else if (op == 8'hE9) begin t = 1; c = 6; end
    else if (op[7:6] == 2'b11 && op[2:0] == 3'b010) begin t = met; c = met ? 5'd10 : 5'd7; end
    else if (op[7:6] == 2'b11 && op[2:0] == 3'b100) begin t = met; pu = met; c = met ? 5'd18 : 5'd9; end
    else if (op[7:6] == 2'b11 && op[2:0] == 3'b000) begin t = met; po = met; c = met ? 5'd12 : 5'd6; end
    else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin t = 1; pu = 1; v = {10'd0, op[5:3], 3'd0}; c = 12; end
    return {t, pu, po, v, c};
  endfunction

  function automatic string reqOf(input logic [7:0] op);
    if (op == 8'hC3 || op == 8'hCD || op == 8'hC9 || op == 8'hE9) return "R5";
    if (op[7:6] != 2'b11) return "R7";
    case (op[2:0])
      3'b010: return "R2/R1";
      3'b100: return "R3/R1";
      3'b000: return "R4/R1";
      3'b111: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%02h flags=%02h actual=%07h expected=%07h", req, opcode, flags, act, exp);
    end
  endtask

  // drive one cycle, sample result after the next edge
  task automatic step(input logic v, input logic [7:0] op, input logic [7:0] f, input string req);
    logic [24:0] exp;
    @(negedge clk);
    opValid = v; opcode = op; flags = f;
    exp = v ? {1'b1, refModel(op, f)} : 25'd0;
    @(negedge clk);
    check(req, {outValid, taken, pushReq, popReq, vectorAddr, stateCount}, exp);
  endtask

  task automatic finishRun;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", {outValid, taken, pushReq, popReq, vectorAddr, stateCount}, 25'd0);
    opValid = 1'b1; opcode = 8'hCD;
    @(negedge clk);
    check("R9", {outValid, taken, pushReq, popReq, vectorAddr, stateCount}, 25'd0);
    opValid = 1'b0;
    rstN = 1'b1;

    // directed corners
    step(1, 8'hCA, 8'h40, "R2");     // jump on zero, Z set: taken 10
    step(1, 8'hCA, 8'hBF, "R2");     // Z clear, others set: 7
    step(1, 8'hDC, 8'h01, "R3");     // call on carry, taken 18
    step(1, 8'hDC, 8'hFE, "R3");     // not taken 9
    step(1, 8'hF0, 8'h80, "R4");     // return on plus, S set: 6
    step(1, 8'hF0, 8'h7F, "R4");     // taken 12
    step(1, 8'hEA, 8'h04, "R1");     // parity even
    step(1, 8'hE2, 8'h04, "R1");     // parity odd, not taken
    step(1, 8'hFA, 8'h3B, "R1");     // minus with unrelated bits set
    step(1, 8'hC3, 8'h00, "R5");
    step(1, 8'hCD, 8'hFF, "R5");
    step(1, 8'hC9, 8'h00, "R5");
    step(1, 8'hE9, 8'h55, "R5");
    step(1, 8'hC7, 8'hFF, "R6");     // vector 0x00
    step(1, 8'hFF, 8'h00, "R6");     // vector 0x38
    step(1, 8'hDF, 8'h00, "R6");     // vector 0x18
    step(1, 8'h00, 8'hFF, "R7");
    step(1, 8'hCB, 8'hFF, "R7");
    step(1, 8'hC1, 8'hFF, "R7");
    step(0, 8'hCD, 8'hFF, "R8");     // idle clears
    step(1, 8'hFF, 8'h00, "R8");
    step(0, 8'hFF, 8'h00, "R8");

    // constrained random: bias toward the 0xC0-0xFF control-transfer region
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op, f;
      logic v;
      op = 8'($urandom(seed));
      seed = seed + 1;
      if (op[0] || op[1]) op[7:6] = 2'b11;
      f = 8'($urandom(seed));
      seed = seed + 1;
      v = ($urandom(seed) % 8) != 0;
      seed = seed + 1;
      step(v, op, f, v ? reqOf(op) : "R8");
      if (pushReq && popReq) begin
        checks++; errors++;
        $display("FAIL R10 actual=push&pop expected=exclusive");
      end
    end

    finishRun();
  end

endmodule